// File: doc/BRIEF.md
# Multicore Low-Power State Controller

This block decides, for a small cluster of processor cores and the chip around them, how much of the logic is allowed to run. Each core asks for one of three activity levels through a two-bit request. The block answers with a dispatch halt, a core clock enable and a snoop enable for that core. A core that asks to nap must first have its data cache flushed, so the block raises a flush request and waits for flush-done before it gates the core clock. While it waits, the core stays halted with its clock still running.

At chip level, a target input selects how deep the chip may go once every core naps. The chip then walks one state per clock: from full-on (LPM10), through the light sleep LPM20 with the time base stopped, through the one-cycle staging state LPM35, into deep sleep, where the switchable supply enable drops. An enabled wake event restores the supply. The block then waits for a power-good input, turns the domain clocks back on, clears the asleep indication and finally forces every core back to Run. A wake event, a core leaving Nap, or a lowered target seen in LPM20 or LPM35 unwinds to LPM10 at once.

Wake events are masked per source and pass through a synchroniser chain of WAKE_SYNC stages (default 1) before the chip sequencer sees them.

Top module: `lp_state_ctl`

## Requirements
- R1: A core request is coded 0 = Run, 1 = Doze, 2 = Nap, 3 = Run. In Doze the core is halted while its clock and snoop enable stay high; in Run all three outputs show a running core (halt low, clock and snoop high).
- R2: In Nap the core's halt stays high and both its clock enable and its snoop enable are low.
- R3: A Nap request first moves the core into a flush wait, where flush_req is high and the core is halted with its clock running. The core enters Nap on the clock edge that samples flush_done high, and not before.
- R4: An interrupt to a core, sampled at a clock edge, puts that core in Run whatever its state, and cancels a pending flush wait.
- R5: In LPM10 asleep is low, the time-base clock enable is high and dom_clk_en is 3'b111 (bit 2 always-on domain, bit 1 wake-logic domain, bit 0 main domain).
- R6: The chip leaves LPM10 for LPM20 only when the target is nonzero (1 or 3 = LPM20, 2 = deep sleep), every core naps, and no synchronised wake is pending. LPM20 shows asleep high, the time base stopped and dom_clk_en = 3'b110.
- R7: With target 2, LPM20 is followed by exactly one cycle of LPM35 (asleep high, dom_clk_en = 3'b100, supply still on) and then by deep sleep, where sw_supply_en is low.
- R8: Wake sources are enabled by wake_mask, bit for bit; a masked source has no effect. An enabled source takes effect two clock edges after it is applied (one synchroniser stage) and restores sw_supply_en with dom_clk_en = 3'b100. The block holds there until sw_pgood is sampled high. It then spends one cycle with dom_clk_en = 3'b111 and asleep still high, and then enters LPM10.
- R9: In LPM20 or LPM35, a synchronised wake, any core not in Nap, or a target that no longer allows the current depth returns the chip to LPM10 on the next edge.
- R10: Whenever the chip enters LPM10 from a deeper state, every core is put in Run on the following clock edge.
- R11: sw_supply_en is never high while aon_ok is low. After reset the chip is in LPM10 with every core in Run, so the supply enable follows aon_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aon_ok | input | 1 | Always-on supply is valid |
| core_req | input | 2*NUM_CORES | Per-core activity request, 2 bits per core |
| core_irq | input | NUM_CORES | Per-core interrupt, also a wake from Nap |
| flush_done | input | NUM_CORES | Per-core data cache flush complete |
| flush_req | output | NUM_CORES | Per-core flush request |
| core_halt | output | NUM_CORES | Per-core instruction dispatch halt |
| core_clk_en | output | NUM_CORES | Per-core clock enable |
| core_snoop_en | output | NUM_CORES | Per-core snoop response enable |
| tb_clk_en | output | 1 | Time-base clock enable |
| sleep_target | input | 2 | Deepest chip state allowed |
| wake_evt | input | NUM_WAKE | Wake sources (network, USB, GPIO, timer) |
| wake_mask | input | NUM_WAKE | Per-source wake enable |
| sw_pgood | input | 1 | Switchable supply power-good |
| asleep | output | 1 | Chip is in a sleep or exit state |
| dom_clk_en | output | 3 | Domain clock enables {always-on, wake logic, main} |
| sw_supply_en | output | 1 | Switchable supply enable |

## Verification
The embedded properties check on every cycle that Nap is entered only from a flush wait that saw flush-done, that a flush wait persists until flush-done or a wake, and that an interrupt always leaves the core un-halted. They also check that deep sleep is reached only through LPM35, that the exit clock state follows a sampled power-good, that LPM20 is entered only when all cores nap, and that the supply enable never outruns aon_ok. The bench's scenarios are what show the sequence as a whole: the exact cycle counts of a full entry and exit, masked sources being ignored, abort unwinding, and the forced return of every core to Run one edge after LPM10 is re-entered.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

   typedef enum logic [1:0] {
      C_RUN   = 2'd0,
      C_DOZE  = 2'd1,
      C_FLUSH = 2'd2,
      C_NAP   = 2'd3
   } core_st_e;

   typedef enum logic [2:0] {
      CH_L10  = 3'd0,
      CH_L20  = 3'd1,
      CH_L35  = 3'd2,
      CH_DEEP = 3'd3,
      CH_XPWR = 3'd4,
      CH_XCLK = 3'd5
   } chip_st_e;

   localparam logic [1:0] REQ_DOZE = 2'd1;
   localparam logic [1:0] REQ_NAP  = 2'd2;

   localparam logic [1:0] TGT_STAY = 2'd0;
   localparam logic [1:0] TGT_DEEP = 2'd2;

   localparam int         DOM_W    = 3;
   localparam logic [DOM_W-1:0] DOM_FULL = 3'b111;
   localparam logic [DOM_W-1:0] DOM_WAKE = 3'b110;
   localparam logic [DOM_W-1:0] DOM_AON  = 3'b100;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int NUM_WAKE = 4,
   parameter int STAGES   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] evt,
   input  logic [NUM_WAKE-1:0] mask,
   output logic                hit
);

   initial begin
      assert (NUM_WAKE >= 1) else $error("NUM_WAKE must be at least 1");
      assert (STAGES >= 1)   else $error("STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= |(evt & mask);
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[k] <= 1'b0;
         else        chain[k] <= chain[k-1];
      end
   end

   assign hit = chain[STAGES-1];

endmodule

// File: rtl/pwr_core_ctl.sv
module pwr_core_ctl
   import pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   input  logic       irq,
   input  logic       flush_done,
   input  logic       force_run,
   output logic       halt,
   output logic       clk_en,
   output logic       snoop_en,
   output logic       flush_req,
   output logic       napping
);

   core_st_e st, nxt;

   always_comb begin
      nxt = st;
      if (irq || force_run) begin
         nxt = C_RUN;
      end else begin
         case (st)
            C_RUN: begin
               if (req == REQ_DOZE)     nxt = C_DOZE;
               else if (req == REQ_NAP) nxt = C_FLUSH;
            end
            C_DOZE: begin
               if (req == REQ_NAP)       nxt = C_FLUSH;
               else if (req != REQ_DOZE) nxt = C_RUN;
            end
            C_FLUSH: if (flush_done) nxt = C_NAP;
            C_NAP:   nxt = C_NAP;
            default: nxt = C_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= C_RUN;
      else        st <= nxt;
   end

   assign halt      = (st != C_RUN);
   assign clk_en    = (st != C_NAP);
   assign snoop_en  = (st != C_NAP);
   assign flush_req = (st == C_FLUSH);
   assign napping   = (st == C_NAP);

   // R3: Nap is only reached from a flush wait that saw flush_done
   p_nap_after_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(napping) |-> ($past(flush_req) && $past(flush_done)));

   // R3: the flush wait persists until flush_done or a wake
   p_flush_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !flush_done && !irq && !force_run) |=> flush_req);

   // R4: an interrupt always leaves the core running
   p_irq_to_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !halt);

endmodule

// File: rtl/pwr_chip_seq.sv
module pwr_chip_seq
   import pwr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             aon_ok,
   input  logic             all_nap,
   input  logic [1:0]       target,
   input  logic             wake_hit,
   input  logic             sw_pgood,
   output logic             asleep,
   output logic             tb_clk_en,
   output logic [DOM_W-1:0] dom_clk_en,
   output logic             sw_supply_en,
   output logic             force_run
);

   chip_st_e st, nxt;
   logic     force_q;

   always_comb begin
      nxt = st;
      case (st)
         CH_L10:  if (target != TGT_STAY && all_nap && !wake_hit && !force_q) nxt = CH_L20;
         CH_L20: begin
            if (wake_hit || !all_nap || target == TGT_STAY) nxt = CH_L10;
            else if (target == TGT_DEEP)                    nxt = CH_L35;
         end
         CH_L35: begin
            if (wake_hit || !all_nap || target != TGT_DEEP) nxt = CH_L10;
            else                                            nxt = CH_DEEP;
         end
         CH_DEEP: if (wake_hit) nxt = CH_XPWR;
         CH_XPWR: if (sw_pgood) nxt = CH_XCLK;
         CH_XCLK: nxt = CH_L10;
         default: nxt = CH_L10;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= CH_L10;
         force_q <= 1'b0;
      end else begin
         st      <= nxt;
         force_q <= (nxt == CH_L10) && (st != CH_L10);
      end
   end

   always_comb begin
      case (st)
         CH_L10, CH_XCLK: dom_clk_en = DOM_FULL;
         CH_L20:          dom_clk_en = DOM_WAKE;
         default:         dom_clk_en = DOM_AON;
      endcase
   end

   assign asleep       = (st != CH_L10);
   assign tb_clk_en    = (st == CH_L10);
   assign sw_supply_en = aon_ok && (st != CH_DEEP);
   assign force_run    = force_q;

   // R7: deep sleep is entered only through LPM35
   p_deep_via_l35_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_DEEP && $past(st) != CH_DEEP) |-> ($past(st) == CH_L35));

   // R8: clocks return only after power-good was sampled
   p_exit_pgood_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_XCLK) |-> ($past(sw_pgood) && $past(st) == CH_XPWR));

   // R6: light sleep is entered only with every core napping
   p_l20_all_nap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_L20 && $past(st) == CH_L10) |-> $past(all_nap));

   // R11: switchable supply never ahead of the always-on supply
   p_supply_aon_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sw_supply_en |-> aon_ok);

endmodule

// File: rtl/lp_state_ctl.sv
module lp_state_ctl
   import pwr_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_WAKE  = 4,
   parameter int WAKE_SYNC = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   aon_ok,
   input  logic [2*NUM_CORES-1:0] core_req,
   input  logic [NUM_CORES-1:0]   core_irq,
   input  logic [NUM_CORES-1:0]   flush_done,
   output logic [NUM_CORES-1:0]   flush_req,
   output logic [NUM_CORES-1:0]   core_halt,
   output logic [NUM_CORES-1:0]   core_clk_en,
   output logic [NUM_CORES-1:0]   core_snoop_en,
   output logic                   tb_clk_en,
   input  logic [1:0]             sleep_target,
   input  logic [NUM_WAKE-1:0]    wake_evt,
   input  logic [NUM_WAKE-1:0]    wake_mask,
   input  logic                   sw_pgood,
   output logic                   asleep,
   output logic [DOM_W-1:0]       dom_clk_en,
   output logic                   sw_supply_en
);

   localparam int REQ_W = 2;

   initial begin
      assert (NUM_CORES >= 1) else $error("NUM_CORES must be at least 1");
   end

   logic [NUM_CORES-1:0] nap_vec;
   logic                 force_run;
   logic                 wake_hit;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      pwr_core_ctl u_core (
         .clk        (clk),
         .rst_n      (rst_n),
         .req        (core_req[REQ_W*i +: REQ_W]),
         .irq        (core_irq[i]),
         .flush_done (flush_done[i]),
         .force_run  (force_run),
         .halt       (core_halt[i]),
         .clk_en     (core_clk_en[i]),
         .snoop_en   (core_snoop_en[i]),
         .flush_req  (flush_req[i]),
         .napping    (nap_vec[i])
      );
   end

   pwr_wake_sync #(
      .NUM_WAKE (NUM_WAKE),
      .STAGES   (WAKE_SYNC)
   ) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (wake_evt),
      .mask  (wake_mask),
      .hit   (wake_hit)
   );

   pwr_chip_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .aon_ok       (aon_ok),
      .all_nap      (&nap_vec),
      .target       (sleep_target),
      .wake_hit     (wake_hit),
      .sw_pgood     (sw_pgood),
      .asleep       (asleep),
      .tb_clk_en    (tb_clk_en),
      .dom_clk_en   (dom_clk_en),
      .sw_supply_en (sw_supply_en),
      .force_run    (force_run)
   );

endmodule

// File: tb/tb_lp_state_ctl.sv
module tb_lp_state_ctl;

   localparam int NC = 4;
   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          aon_ok = 1'b1;
   logic [2*NC-1:0] core_req = '0;
   logic [NC-1:0] core_irq = '0;
   logic [NC-1:0] flush_done = '0;
   logic [NC-1:0] flush_req, core_halt, core_clk_en, core_snoop_en;
   logic          tb_clk_en;
   logic [1:0]    sleep_target = 2'd0;
   logic [NW-1:0] wake_evt = '0;
   logic [NW-1:0] wake_mask = '0;
   logic          sw_pgood = 1'b0;
   logic          asleep;
   logic [2:0]    dom_clk_en;
   logic          sw_supply_en;

   always #2 clk = ~clk;

   lp_state_ctl #(.NUM_CORES(NC), .NUM_WAKE(NW), .WAKE_SYNC(1)) dut (
      .clk(clk), .rst_n(rst_n), .aon_ok(aon_ok), .core_req(core_req),
      .core_irq(core_irq), .flush_done(flush_done), .flush_req(flush_req),
      .core_halt(core_halt), .core_clk_en(core_clk_en),
      .core_snoop_en(core_snoop_en), .tb_clk_en(tb_clk_en),
      .sleep_target(sleep_target), .wake_evt(wake_evt), .wake_mask(wake_mask),
      .sw_pgood(sw_pgood), .asleep(asleep), .dom_clk_en(dom_clk_en),
      .sw_supply_en(sw_supply_en)
   );

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   // reference state: core 0 run,1 doze,2 flush,3 nap; chip 0 L10,1 L20,2 L35,3 deep,4 xpwr,5 xclk
   int  m_core [NC];
   int  m_chip = 0;
   bit  m_force = 1'b0;
   bit  m_wake = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int core_next(int cs, int rq, bit irq, bit fd, bit frc);
      if (irq || frc) return 0;
      case (cs)
         0: return (rq == 1) ? 1 : (rq == 2) ? 2 : 0;
         1: return (rq == 2) ? 2 : (rq == 1) ? 1 : 0;
         2: return fd ? 3 : 2;
         default: return 3;
      endcase
   endfunction

   function automatic int chip_next(int st, int tgt, bit alln, bit wk, bit pg, bit frc);
      case (st)
         0: return (tgt != 0 && alln && !wk && !frc) ? 1 : 0;
         1: return (wk || !alln || tgt == 0) ? 0 : (tgt == 2) ? 2 : 1;
         2: return (wk || !alln || tgt != 2) ? 0 : 3;
         3: return wk ? 4 : 3;
         4: return pg ? 5 : 4;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_dom(int st);
      if (st == 0 || st == 5) return 7;
      if (st == 1) return 6;
      return 4;
   endfunction

   task automatic compare_all();
      for (int i = 0; i < NC; i++) begin
         chk("R1 core_halt", int'(core_halt[i]), int'(m_core[i] != 0));
         chk("R2 core_clk_en", int'(core_clk_en[i]), int'(m_core[i] != 3));
         chk("R2 core_snoop_en", int'(core_snoop_en[i]), int'(m_core[i] != 3));
         chk("R3 flush_req", int'(flush_req[i]), int'(m_core[i] == 2));
      end
      chk("R5 tb_clk_en", int'(tb_clk_en), int'(m_chip == 0));
      chk("R6 asleep", int'(asleep), int'(m_chip != 0));
      chk("R7 dom_clk_en", int'(dom_clk_en), exp_dom(m_chip));
      chk("R8 sw_supply_en", int'(sw_supply_en), int'(aon_ok && m_chip != 3));
   endtask

   task automatic tick();
      bit alln = 1'b1;
      int nxt_chip;
      @(posedge clk);
      #1;
      for (int i = 0; i < NC; i++) alln &= (m_core[i] == 3);
      nxt_chip = chip_next(m_chip, int'(sleep_target), alln, m_wake, sw_pgood, m_force);
      for (int i = 0; i < NC; i++)
         m_core[i] = core_next(m_core[i], int'(core_req[2*i +: 2]), core_irq[i],
                               flush_done[i], m_force);
      m_force = (nxt_chip == 0) && (m_chip != 0);
      m_wake  = |(wake_evt & wake_mask);
      m_chip  = nxt_chip;
      compare_all();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      for (int i = 0; i < NC; i++) m_core[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11 reset asleep", int'(asleep), 0);
      chk("R11 reset supply", int'(sw_supply_en), 1);
      chk("R5 reset dom", int'(dom_clk_en), 7);
      chk("R1 reset halt", int'(core_halt), 0);
      rst_n = 1'b1;
      tick();

      // R1 doze on core 1
      core_req = 8'b0000_0100;
      tick();
      chk("R1 doze halted", int'(core_halt[1]), 1);
      chk("R1 doze clock on", int'(core_clk_en[1]), 1);

      // R3/R4 flush wait then cancel by interrupt
      core_req = 8'b0000_0010;
      tick();
      tick();
      chk("R3 flush wait held", int'(flush_req[0]), 1);
      chk("R3 no nap without flush_done", int'(core_clk_en[0]), 1);
      core_irq = 4'b0001;
      tick();
      chk("R4 irq cancels flush", int'(core_halt[0]), 0);
      core_irq = '0;
      core_req = '0;
      tick();

      // R7/R8/R10 deep sleep round trip
      core_req = 8'b1010_1010;
      flush_done = '1;
      sleep_target = 2'd2;
      wake_mask = 4'b0001;
      tick();
      tick();
      chk("R2 nap clock gated", int'(core_clk_en), 0);
      core_req = '0;
      tick();
      chk("R6 light sleep tb stopped", int'(tb_clk_en), 0);
      chk("R6 light sleep dom", int'(dom_clk_en), 6);
      tick();
      chk("R7 staging dom", int'(dom_clk_en), 4);
      chk("R7 staging supply on", int'(sw_supply_en), 1);
      tick();
      chk("R7 deep supply off", int'(sw_supply_en), 0);
      wake_evt = 4'b0010;
      tick();
      tick();
      chk("R8 masked wake ignored", int'(sw_supply_en), 0);
      wake_evt = 4'b0001;
      tick();
      chk("R8 wake synchroniser delay", int'(sw_supply_en), 0);
      tick();
      wake_evt = '0;
      chk("R8 supply restored", int'(sw_supply_en), 1);
      tick();
      chk("R8 wait power good", int'(dom_clk_en), 4);
      sw_pgood = 1'b1;
      tick();
      chk("R8 clocks back", int'(dom_clk_en), 7);
      chk("R8 still asleep", int'(asleep), 1);
      tick();
      chk("R8 back in LPM10", int'(asleep), 0);
      tick();
      chk("R10 cores forced to run", int'(core_halt), 0);

      // R9 abort from light sleep by lowering target
      core_req = 8'b1010_1010;
      sleep_target = 2'd1;
      tick();
      tick();
      tick();
      chk("R9 light sleep reached", int'(asleep), 1);
      sleep_target = 2'd0;
      tick();
      chk("R9 abort to LPM10", int'(asleep), 0);
      tick();
      chk("R10 forced run after abort", int'(core_halt), 0);
      core_req = '0;
      tick();

      // R11 supply follows the always-on supply
      aon_ok = 1'b0;
      #1;
      chk("R11 supply needs aon", int'(sw_supply_en), 0);
      aon_ok = 1'b1;
      tick();

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         for (int i = 0; i < NC; i++) begin
            if ($urandom_range(0, 7) == 0) core_req[2*i +: 2] = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 2) != 0 && core_req[2*i +: 2] != 2'd2)
               core_req[2*i +: 2] = 2'd2;
            core_irq[i]   = ($urandom_range(0, 39) == 0);
            flush_done[i] = ($urandom_range(0, 2) == 0);
         end
         if ($urandom_range(0, 49) == 0) sleep_target = 2'($urandom_range(0, 3));
         wake_evt  = ($urandom_range(0, 29) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
         if ($urandom_range(0, 99) == 0) wake_mask = 4'($urandom_range(0, 15));
         sw_pgood  = ($urandom_range(0, 3) == 0);
         aon_ok    = ($urandom_range(0, 199) != 0);
         tick();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule